// File: doc/BRIEF.md
# Serial Line Transceiver Power Sequencer

This controller decides when a multi-channel serial line interface may draw power. External comparators report, one flag per receive channel, whether each line carries a valid signalling level. From these flags the controller derives a qualified "line live" status, which is low while the line is idle. The status falls only after every channel has been idle for a long, programmable time. It rises again after a short time once any channel becomes valid. The controller also drives a charge-pump run request and a transmitter enable. The transmitter enable is raised only after the pump's rail monitor reports ready.

Three control inputs set the policy, and they are ranked. An active-low sleep input turns everything off and wins over all other inputs. An active-high stay-awake input keeps the transmit side powered whatever the line state. With neither of them active, the block runs an automatic mode. In that mode it powers down when the line is idle and wakes on a fresh valid level. After a wake, the line must qualify as live within a programmable window, or the block returns to sleep.

The main receiver output enable follows the sleep input and an active-low receiver enable. It stays on during an automatic power-down. The always-on monitor receiver path is reported as enabled. All time limits are counted in clock cycles. Every input passes through a two-flop synchronizer.

Top module: `xcvr_pwr_ctrl`

## Requirements
- R1: While `sleep_n` is low, `tx_en` and `pump_req` are low three cycles after it is sampled low, whatever `stay_awake`, `rail_ok` or the line flags are doing.
- R2: With `sleep_n` high and `stay_awake` high, `pump_req` is high three cycles after they are sampled. `tx_en` follows once the rail is ready, and both stay high while the line is idle.
- R3: `line_live` falls exactly IDLE_CYC+2 cycles after the last `rx_valid` bit goes low, provided all bits stay low for that time.
- R4: `line_live` rises exactly LIVE_CYC+2 cycles after any `rx_valid` bit goes high and stays high.
- R5: Any change of the OR of `rx_valid` before the qualification completes restarts the count. A one-cycle valid pulse during an idle count moves the fall of `line_live` to IDLE_CYC+3 cycles after the pulse.
- R6: `line_live` is qualified the same way in automatic mode, in stay-awake mode and during sleep.
- R7: In automatic mode, `tx_en` and `pump_req` go low one cycle after `line_live` falls.
- R8: In automatic mode with the block powered down, a rising OR of `rx_valid` raises `pump_req` three cycles later. `tx_en` stays low until `line_live` is high and `rail_ok` is ready.
- R9: After an automatic wake, if `line_live` has not risen by then, `pump_req` drops WAKE_CYC+3 cycles after the valid edge, and `line_live` stays low.
- R10: `tx_en` is high only when `rail_ok` was high three cycles earlier. A drop of `rail_ok` clears `tx_en` three cycles later while `pump_req` stays high, and its return restores `tx_en` three cycles later.
- R11: `rx_oe` equals `sleep_n` high and `rx_en_n` low, three cycles after those inputs are sampled. It stays high during an automatic power-down.
- R12: `mon_active` is high at all times.
- R13: During reset, `tx_en`, `pump_req`, `line_live` and `rx_oe` are low, so the block starts powered down with the line idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | NUM_RX | Per-channel valid-level flags from the comparators (asynchronous) |
| sleep_n | input | 1 | Manual power-down, active low, dominant |
| stay_awake | input | 1 | Keeps the transmit side powered, disables automatic power-down |
| rx_en_n | input | 1 | Active-low enable for the main receiver outputs |
| rail_ok | input | 1 | Charge-pump rail monitor reports ready |
| tx_en | output | 1 | Transmitter enable |
| rx_oe | output | 1 | Main receiver output enable |
| pump_req | output | 1 | Charge-pump run request |
| line_live | output | 1 | Qualified line status, low when the line is idle |
| mon_active | output | 1 | Monitor receiver path enabled |

## Verification
The timing properties assume that each input holds its value across at least one sampling edge. This makes the three-cycle synchronizer-plus-register latency exact, and it lets the line-status edges be traced back to the port value three cycles earlier. The bench changes every input only on falling clock edges and holds each level for at least one full cycle. The single-cycle pulses used to test the restart and the wake window still span exactly one rising edge. The rail-ready input is driven as a free stimulus rather than modelled as a pump, so the transmitter gating is exercised with the rail both rising and falling.

// File: rtl/xcvr_pwr_pkg.sv
package xcvr_pwr_pkg;
  typedef enum logic [1:0] {
    PS_DOWN = 2'd0,
    PS_RAMP = 2'd1,
    PS_UP   = 2'd2
  } pwr_state_t;
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        meta[i] <= 1'b0;
        q[i]    <= 1'b0;
      end else begin
        meta[i] <= d[i];
        q[i]    <= meta[i];
      end
    end
  end
endmodule

// File: rtl/line_qual.sv
module line_qual #(
  parameter int LIVE_CYC = 10,
  parameter int IDLE_CYC = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic any_live,
  output logic line_live
);
  localparam int MAXC = (IDLE_CYC > LIVE_CYC) ? IDLE_CYC : LIVE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] RISE_LAST = CW'(LIVE_CYC - 1);
  localparam logic [CW-1:0] FALL_LAST = CW'(IDLE_CYC - 1);

  logic [CW-1:0] cnt;
  logic          live_q;
  logic          hit;

  always_comb begin
    hit = live_q ? (cnt == FALL_LAST) : (cnt == RISE_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= 1'b0;
      cnt    <= '0;
    end else if (any_live == live_q) begin
      cnt <= '0;
    end else if (hit) begin
      live_q <= any_live;
      cnt    <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign line_live = live_q;
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import xcvr_pwr_pkg::*;
#(
  parameter int WAKE_CYC = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_s,
  input  logic awake_s,
  input  logic rail_s,
  input  logic any_live,
  input  logic line_live,
  output logic tx_en,
  output logic pump_req
);
  localparam int WW = $clog2(WAKE_CYC + 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(WAKE_CYC - 1);

  pwr_state_t st, nxt;
  logic [WW-1:0] win;
  logic          any_d;
  logic          rise;

  always_comb begin
    rise = any_live & ~any_d;
    nxt  = st;
    if (!sleep_s) begin
      nxt = PS_DOWN;
    end else if (awake_s) begin
      case (st)
        PS_DOWN: nxt = PS_RAMP;
        PS_RAMP: if (rail_s) nxt = PS_UP;
        PS_UP:   if (!rail_s) nxt = PS_RAMP;
        default: nxt = PS_DOWN;
      endcase
    end else begin
      case (st)
        PS_DOWN: if (rise || line_live) nxt = PS_RAMP;
        PS_RAMP: begin
          if (line_live && rail_s) nxt = PS_UP;
          else if (win == WIN_LAST) nxt = PS_DOWN;
        end
        PS_UP: begin
          if (!line_live) nxt = PS_DOWN;
          else if (!rail_s) nxt = PS_RAMP;
        end
        default: nxt = PS_DOWN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= PS_DOWN;
      win      <= '0;
      any_d    <= 1'b0;
      tx_en    <= 1'b0;
      pump_req <= 1'b0;
    end else begin
      st       <= nxt;
      any_d    <= any_live;
      tx_en    <= (nxt == PS_UP);
      pump_req <= (nxt != PS_DOWN);
      if (nxt == PS_RAMP && st != PS_RAMP) win <= '0;
      else if (st == PS_RAMP && win != WIN_LAST) win <= win + 1'b1;
    end
  end
endmodule

// File: rtl/xcvr_pwr_ctrl.sv
module xcvr_pwr_ctrl #(
  parameter int NUM_RX   = 5,
  parameter int LIVE_CYC = 10,
  parameter int IDLE_CYC = 200,
  parameter int WAKE_CYC = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_RX-1:0] rx_valid,
  input  logic              sleep_n,
  input  logic              stay_awake,
  input  logic              rx_en_n,
  input  logic              rail_ok,
  output logic              tx_en,
  output logic              rx_oe,
  output logic              pump_req,
  output logic              line_live,
  output logic              mon_active
);
  localparam int SW = NUM_RX + 4;

  logic [SW-1:0]     raw, synced;
  logic [NUM_RX-1:0] valid_s;
  logic              sleep_s, awake_s, rxen_s, rail_s;
  logic              any_live;
  logic              rx_oe_q;

  assign raw = {rx_valid, sleep_n, stay_awake, rx_en_n, rail_ok};

  pwr_sync #(.W(SW)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .q   (synced)
  );

  assign {valid_s, sleep_s, awake_s, rxen_s, rail_s} = synced;
  assign any_live = |valid_s;

  line_qual #(.LIVE_CYC(LIVE_CYC), .IDLE_CYC(IDLE_CYC)) u_qual (
    .clk       (clk),
    .rst       (rst),
    .any_live  (any_live),
    .line_live (line_live)
  );

  pwr_seq #(.WAKE_CYC(WAKE_CYC)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .sleep_s   (sleep_s),
    .awake_s   (awake_s),
    .rail_s    (rail_s),
    .any_live  (any_live),
    .line_live (line_live),
    .tx_en     (tx_en),
    .pump_req  (pump_req)
  );

  always_ff @(posedge clk) begin
    if (rst) rx_oe_q <= 1'b0;
    else     rx_oe_q <= sleep_s & ~rxen_s;
  end

  assign rx_oe      = rx_oe_q;
  assign mon_active = 1'b1;
endmodule

// File: rtl/xcvr_pwr_ctrl_chk.sv
module xcvr_pwr_ctrl_chk #(
  parameter int NUM_RX = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_RX-1:0] rx_valid,
  input logic              sleep_n,
  input logic              stay_awake,
  input logic              rx_en_n,
  input logic              rail_ok,
  input logic              tx_en,
  input logic              rx_oe,
  input logic              pump_req,
  input logic              line_live
);
  logic [2:0] age;
  logic       age_ok;

  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 3'd7) age <= age + 1'b1;
  end
  assign age_ok = (age >= 3'd4);

  AST_SLEEP_WINS: assert property (@(posedge clk) disable iff (rst)
    (age_ok && !$past(sleep_n, 3)) |-> (!tx_en && !pump_req)); // R1

  AST_AWAKE_PUMPS: assert property (@(posedge clk) disable iff (rst)
    (age_ok && $past(sleep_n, 3) && $past(stay_awake, 3)) |-> pump_req); // R2

  AST_FALL_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (age_ok && $fell(line_live)) |-> ($past(rx_valid, 3) == '0)); // R3

  AST_RISE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    (age_ok && $rose(line_live)) |-> (|$past(rx_valid, 3))); // R4

  AST_TX_NEEDS_RAIL: assert property (@(posedge clk) disable iff (rst)
    (age_ok && tx_en) |-> $past(rail_ok, 3)); // R10

  AST_RXOE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    age_ok |-> (rx_oe == ($past(sleep_n, 3) && !$past(rx_en_n, 3)))); // R11
endmodule

bind xcvr_pwr_ctrl xcvr_pwr_ctrl_chk #(.NUM_RX(NUM_RX)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rx_valid   (rx_valid),
  .sleep_n    (sleep_n),
  .stay_awake (stay_awake),
  .rx_en_n    (rx_en_n),
  .rail_ok    (rail_ok),
  .tx_en      (tx_en),
  .rx_oe      (rx_oe),
  .pump_req   (pump_req),
  .line_live  (line_live)
);

// File: tb/xcvr_pwr_ctrl_bench.sv
module xcvr_pwr_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NRX  = 5;
  localparam int LIVE = 6;
  localparam int IDLE = 40;
  localparam int WAKE = 30;

  localparam int S_TX = 0, S_PUMP = 1, S_LIVE = 2, S_OE = 3, S_MON = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NRX-1:0] rx_valid = '0;
  logic           sleep_n = 1'b1, stay_awake = 1'b0, rx_en_n = 1'b0, rail_ok = 1'b0;
  logic           tx_en, rx_oe, pump_req, line_live, mon_active;

  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  typedef struct {
    int    at;
    int    sig;
    bit    val;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  xcvr_pwr_ctrl #(.NUM_RX(NRX), .LIVE_CYC(LIVE), .IDLE_CYC(IDLE), .WAKE_CYC(WAKE))
  u_xcvr_pwr_ctrl (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .sleep_n(sleep_n),
    .stay_awake(stay_awake), .rx_en_n(rx_en_n), .rail_ok(rail_ok),
    .tx_en(tx_en), .rx_oe(rx_oe), .pump_req(pump_req),
    .line_live(line_live), .mon_active(mon_active)
  );

  function automatic bit pick(int s);
    case (s)
      S_TX:    return tx_en;
      S_PUMP:  return pump_req;
      S_LIVE:  return line_live;
      S_OE:    return rx_oe;
      default: return mon_active;
    endcase
  endfunction

  function automatic string sname(int s);
    case (s)
      S_TX:    return "tx_en";
      S_PUMP:  return "pump_req";
      S_LIVE:  return "line_live";
      S_OE:    return "rx_oe";
      default: return "mon_active";
    endcase
  endfunction

  task automatic want(input int at, input int sig, input bit val, input string tag);
    exp_t e;
    e.at = at; e.sig = sig; e.val = val; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic go(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // monitor: pops expectations due in this cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at <= cyc) begin
        n_run++;
        if (sb[i].at < cyc || pick(sb[i].sig) !== sb[i].val) begin
          n_fail++;
          $display("FAIL %s %s at cycle %0d: actual=%0b expected=%0b",
                   sb[i].tag, sname(sb[i].sig), cyc, pick(sb[i].sig), sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  initial begin
    int c, d;
    repeat (3) @(negedge clk);
    c = cyc;
    want(c+1, S_TX, 0, "R13");   want(c+1, S_PUMP, 0, "R13");
    want(c+1, S_LIVE, 0, "R13"); want(c+1, S_OE, 0, "R13");
    want(c+1, S_MON, 1, "R12");
    go(c+2);
    rst = 1'b0;
    c = cyc;
    // automatic power-down state: receivers still enabled
    want(c+6, S_OE, 1, "R11"); want(c+6, S_PUMP, 0, "R7");
    want(c+6, S_TX, 0, "R7");  want(c+6, S_LIVE, 0, "R13");
    go(c+8);
    rail_ok = 1'b1;
    go(cyc+4);

    // automatic wake with qualified line
    c = cyc; rx_valid = 5'b00100;
    want(c+2, S_PUMP, 0, "R8");        want(c+3, S_PUMP, 1, "R8");
    want(c+3, S_TX, 0, "R8");
    want(c+LIVE+1, S_LIVE, 0, "R4");   want(c+LIVE+2, S_LIVE, 1, "R4");
    want(c+LIVE+2, S_TX, 0, "R8");     want(c+LIVE+3, S_TX, 1, "R8");
    go(c+LIVE+6);

    // idle count restarted by a one-cycle pulse
    c = cyc; rx_valid = '0;
    want(c+IDLE+2, S_LIVE, 1, "R5");
    go(c+20);
    d = cyc; rx_valid = 5'b10000;
    want(d+IDLE+2, S_LIVE, 1, "R5");   want(d+IDLE+3, S_LIVE, 0, "R3");
    want(d+IDLE+3, S_TX, 1, "R7");     want(d+IDLE+4, S_TX, 0, "R7");
    want(d+IDLE+4, S_PUMP, 0, "R7");   want(d+IDLE+4, S_OE, 1, "R11");
    @(negedge clk); rx_valid = '0;
    go(d+IDLE+6);

    // wake that is not confirmed in the window
    c = cyc; rx_valid = 5'b00001;
    want(c+2, S_PUMP, 0, "R9");        want(c+3, S_PUMP, 1, "R9");
    want(c+5, S_TX, 0, "R8");
    want(c+WAKE+2, S_PUMP, 1, "R9");   want(c+WAKE+3, S_PUMP, 0, "R9");
    want(c+WAKE+3, S_LIVE, 0, "R9");
    @(negedge clk); rx_valid = '0;
    go(c+WAKE+6);

    // stay-awake with an idle line
    c = cyc; stay_awake = 1'b1;
    want(c+2, S_PUMP, 0, "R2"); want(c+3, S_PUMP, 1, "R2");
    want(c+3, S_TX, 0, "R2");   want(c+4, S_TX, 1, "R2");
    want(c+60, S_TX, 1, "R2");  want(c+60, S_LIVE, 0, "R6");
    go(c+61);
    c = cyc; rx_valid = 5'b01000;
    want(c+LIVE+1, S_LIVE, 0, "R6"); want(c+LIVE+2, S_LIVE, 1, "R6");
    go(c+LIVE+4);

    // rail readiness gates the transmitters
    c = cyc; rail_ok = 1'b0;
    want(c+2, S_TX, 1, "R10"); want(c+3, S_TX, 0, "R10");
    want(c+3, S_PUMP, 1, "R10");
    go(c+6);
    c = cyc; rail_ok = 1'b1;
    want(c+2, S_TX, 0, "R10"); want(c+3, S_TX, 1, "R10");
    go(c+5);

    // receiver enable input
    c = cyc; rx_en_n = 1'b1;
    want(c+2, S_OE, 1, "R11"); want(c+3, S_OE, 0, "R11");
    go(c+5);
    c = cyc; rx_en_n = 1'b0;
    want(c+3, S_OE, 1, "R11");
    go(c+5);

    // manual sleep dominates stay-awake and a live line
    c = cyc; sleep_n = 1'b0;
    want(c+2, S_TX, 1, "R1");   want(c+3, S_TX, 0, "R1");
    want(c+3, S_PUMP, 0, "R1"); want(c+3, S_OE, 0, "R11");
    want(c+3, S_LIVE, 1, "R6"); want(c+3, S_MON, 1, "R12");
    go(c+6);
    c = cyc; rx_valid = '0;
    want(c+IDLE+1, S_LIVE, 1, "R6"); want(c+IDLE+2, S_LIVE, 0, "R6");
    go(c+IDLE+4);
    c = cyc; rx_valid = 5'b00010;
    want(c+LIVE+2, S_LIVE, 1, "R6"); want(c+LIVE+3, S_PUMP, 0, "R1");
    want(c+LIVE+3, S_TX, 0, "R1");
    go(c+LIVE+5);

    // leave sleep with stay-awake still high
    c = cyc; sleep_n = 1'b1;
    want(c+3, S_PUMP, 1, "R2"); want(c+3, S_TX, 0, "R2");
    want(c+4, S_TX, 1, "R2");   want(c+3, S_OE, 1, "R11");
    go(c+8);
    while (sb.size() != 0) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule